// File: doc/BRIEF.md
# Reorder Buffer Retire Control

This block keeps the program order of in-flight instructions and lets them leave in that order once they have finished executing. A dispatch stage presents an instruction with its micro-op count and an opaque handle. If the buffer can take it, the block hands back a token, which is the index of the slot it used. A completion stage later names that token to mark the instruction as executed. Every cycle the block looks at the oldest instruction and retires a run of executed instructions from there, up to a configurable number, giving their entries back to the pool.

Entry accounting and slot indexing are kept apart. The slot ring has twice as many positions as the buffer has entries. An instruction needing n entries moves the ring pointer by n positions, or by one position when n is zero, but stores its data only at its first position. An instruction with no micro-ops still uses one ring position and no entries. A request larger than the whole buffer is clamped to the buffer size, so it can still dispatch into an empty buffer.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After a synchronous active-low reset, free_entries equals ENTRIES, disp_token is 0, ret_valid is 0, err is 0 and the ring is empty.
- R2: disp_token always shows the ring tail index. An accepted dispatch moves the tail by max(1, e), where e is the clamped entry count, modulo 2*ENTRIES.
- R3: free_entries drops by e on an accepted dispatch and rises by the stored count of each instruction that retires. A zero-count instruction leaves it unchanged.
- R4: The clamped count e is min(disp_uops, ENTRIES). disp_ready is 1 only when free_entries >= e and the ring has at least max(1, e) unused positions.
- R5: A dispatch request with disp_ready low is ignored, and err is 1 in the following cycle.
- R6: A completion for a token whose slot is empty, is not the first position of an instruction, or is already executed sets err to 1 in the following cycle and changes nothing. A legal completion leaves err 0.
- R7: Retirement starts at the oldest instruction and stops at the first one that has not executed. No younger instruction retires ahead of it.
- R8: At most MAX_RETIRE instructions retire per cycle. MAX_RETIRE = 0 means no limit, so every executed instruction in the run can retire in one cycle.
- R9: ret_valid, ret_count and ret_handle describe the retirement that happens at the next clock edge. ret_handle is the handle of the oldest instruction that retires.
- R10: Zero-count instructions are limited by ring positions. Once all 2*ENTRIES positions are in use, disp_ready is 0 even though entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the instruction being dispatched |
| disp_handle | input | HANDLE_W | Opaque instruction handle, stored with the slot |
| disp_ready | output | 1 | The request can be accepted this cycle |
| disp_token | output | log2(2*ENTRIES) | Token (tail slot index) given to the next accepted dispatch |
| exec_valid | input | 1 | Execution-complete event |
| exec_token | input | log2(2*ENTRIES) | Token of the instruction that completed |
| ret_valid | output | 1 | At least one instruction retires at the next edge |
| ret_count | output | log2(LIMIT+1) | Number of instructions retiring at the next edge |
| ret_handle | output | HANDLE_W | Handle of the oldest retiring instruction |
| free_entries | output | log2(ENTRIES+1) | Entries currently free |
| err | output | 1 | One-cycle pulse after an illegal completion or a refused dispatch |

## Verification
On every cycle, assertions check four things: free_entries never exceeds the buffer size, ret_count stays within the retire limit, a refused dispatch always raises err, and the free count holds still when nothing is dispatched or retired. They also check that each accepted dispatch moves the token by the clamped step, wrapping around the ring. Only the bench scenarios can show the rest: in-order stopping at an unexecuted head, the exact handles that retire, each kind of illegal completion, clamping of oversized requests, and running out of ring positions with zero-count instructions. A second instance with no retire limit shows a full ring draining in a single cycle.

// File: rtl/rcu_pkg.sv
// Package rcu_pkg
// Shared helpers for the retire control block: ring stepping and wrap-around.
// Assumes every index it handles is below the ring size passed in.
package rcu_pkg;

    // Ring positions an instruction occupies: at least one, even for zero entries.
    function automatic int step_of(input int entries);
        return (entries == 0) ? 1 : entries;
    endfunction

    // Wrap an index sum back into the ring; the sum is always below twice the ring size.
    function automatic int wrap_slot(input int sum, input int ring);
        return (sum >= ring) ? (sum - ring) : sum;
    endfunction

endpackage

// File: rtl/rcu_slot_array.sv
// Module rcu_slot_array
// Per-slot storage of the ring: occupied flag, executed flag, entry count and
// handle. Write, mark and clear never target the same slot in one cycle; the
// control logic guarantees this, and clear wins if they ever coincide.
module rcu_slot_array #(
    parameter int NSLOT    = 16,
    parameter int SLOT_W   = 4,
    parameter int CNT_W    = 4,
    parameter int HANDLE_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SLOT_W-1:0]                  wr_idx,
    input  logic [CNT_W-1:0]                   wr_cnt,
    input  logic [HANDLE_W-1:0]                wr_handle,
    input  logic                               mark_en,
    input  logic [SLOT_W-1:0]                  mark_idx,
    input  logic [NSLOT-1:0]                   clr_mask,
    output logic [NSLOT-1:0]                   occ,
    output logic [NSLOT-1:0]                   done,
    output logic [NSLOT-1:0][CNT_W-1:0]        cnt,
    output logic [NSLOT-1:0][HANDLE_W-1:0]     handle
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Slot s: clear on retire, load on dispatch, set executed on completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[s]    <= 1'b0;
                done[s]   <= 1'b0;
                cnt[s]    <= '0;
                handle[s] <= '0;
            end else if (clr_mask[s]) begin
                occ[s]    <= 1'b0;
                done[s]   <= 1'b0;
                cnt[s]    <= '0;
            end else if (wr_en && (int'(wr_idx) == s)) begin
                occ[s]    <= 1'b1;
                done[s]   <= 1'b0;
                cnt[s]    <= wr_cnt;
                handle[s] <= wr_handle;
            end else if (mark_en && (int'(mark_idx) == s)) begin
                done[s]   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcu_retire_scan.sv
// Module rcu_retire_scan
// Combinational walk from the head along the ring, one stage per possible
// retirement. The run stops at the first slot that is empty or not executed.
// Reports the count, the slots to clear, the new head and what is freed.
module rcu_retire_scan #(
    parameter int NSLOT    = 16,
    parameter int SLOT_W   = 4,
    parameter int CNT_W    = 4,
    parameter int HANDLE_W = 8,
    parameter int LIMIT    = 2,
    parameter int RET_W    = 2,
    parameter int USED_W   = 5
) (
    input  logic [SLOT_W-1:0]              head,
    input  logic [NSLOT-1:0]               occ,
    input  logic [NSLOT-1:0]               done,
    input  logic [NSLOT-1:0][CNT_W-1:0]    cnt,
    input  logic [NSLOT-1:0][HANDLE_W-1:0] handle,
    output logic [RET_W-1:0]               ret_num,
    output logic [NSLOT-1:0]               clr_mask,
    output logic [SLOT_W-1:0]              head_next,
    output logic [CNT_W-1:0]               freed_entries,
    output logic [USED_W-1:0]              freed_slots,
    output logic [HANDLE_W-1:0]            first_handle
);
    import rcu_pkg::*;

    logic [SLOT_W-1:0] idx  [LIMIT+1];
    logic              go   [LIMIT];
    logic [LIMIT-1:0]  take;
    int                num_i, ent_i, pos_i;

    assign idx[0] = head;

    for (genvar g = 0; g < LIMIT; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign go[g] = 1'b1;
        end else begin : g_rest
            assign go[g] = take[g-1];
        end
        assign take[g]  = go[g] & occ[idx[g]] & done[idx[g]];
        assign idx[g+1] = SLOT_W'(wrap_slot(int'(idx[g]) + step_of(int'(cnt[idx[g]])), NSLOT));
    end

    // Sum up the retiring run and build the clear mask.
    always_comb begin
        clr_mask  = '0;
        head_next = head;
        num_i     = 0;
        ent_i     = 0;
        pos_i     = 0;
        for (int i = 0; i < LIMIT; i++) begin
            if (take[i]) begin
                clr_mask[idx[i]] = 1'b1;
                head_next        = idx[i+1];
                num_i            = num_i + 1;
                ent_i            = ent_i + int'(cnt[idx[i]]);
                pos_i            = pos_i + step_of(int'(cnt[idx[i]]));
            end
        end
        ret_num       = RET_W'(num_i);
        freed_entries = CNT_W'(ent_i);
        freed_slots   = USED_W'(pos_i);
    end

    assign first_handle = handle[head];

endmodule

// File: rtl/rcu_alloc_ctl.sv
// Module rcu_alloc_ctl
// Owns the head and tail pointers, the free-entry and used-position counters,
// and the error pulse. Clamps oversized requests to the buffer size and judges
// dispatch and completion legality. Assumes the retire scan's freed amounts
// never exceed what is allocated.
module rcu_alloc_ctl #(
    parameter int ENTRIES = 8,
    parameter int NSLOT   = 16,
    parameter int SLOT_W  = 4,
    parameter int CNT_W   = 4,
    parameter int USED_W  = 5,
    parameter int UOP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [UOP_W-1:0]  disp_uops,
    input  logic              exec_valid,
    input  logic [SLOT_W-1:0] exec_token,
    input  logic [NSLOT-1:0]  occ,
    input  logic [NSLOT-1:0]  done,
    input  logic [SLOT_W-1:0] head_next,
    input  logic [CNT_W-1:0]  freed_entries,
    input  logic [USED_W-1:0] freed_slots,
    output logic [SLOT_W-1:0] head,
    output logic [SLOT_W-1:0] tail,
    output logic              disp_ready,
    output logic              disp_fire,
    output logic [CNT_W-1:0]  eff_cnt,
    output logic              mark_en,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              err
);
    import rcu_pkg::*;

    logic [USED_W-1:0] used_q;
    int                req_i, step_i;

    // Clamp the request and decide whether it fits in entries and ring positions.
    always_comb begin
        req_i = int'(disp_uops);
        if (req_i > ENTRIES) req_i = ENTRIES;
        step_i     = step_of(req_i);
        eff_cnt    = CNT_W'(req_i);
        disp_ready = (int'(free_cnt) >= req_i) && ((NSLOT - int'(used_q)) >= step_i);
        disp_fire  = disp_valid & disp_ready;
    end

    // A completion is legal only on an occupied slot that has not executed yet.
    assign mark_en = exec_valid & occ[exec_token] & ~done[exec_token];

    // Pointer and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head     <= '0;
            tail     <= '0;
            free_cnt <= CNT_W'(ENTRIES);
            used_q   <= '0;
        end else begin
            head     <= head_next;
            free_cnt <= CNT_W'(int'(free_cnt) + int'(freed_entries) - (disp_fire ? req_i : 0));
            used_q   <= USED_W'(int'(used_q) - int'(freed_slots) + (disp_fire ? step_i : 0));
            if (disp_fire)
                tail <= SLOT_W'(wrap_slot(int'(tail) + step_i, NSLOT));
        end
    end

    // One-cycle error pulse for a refused dispatch or an illegal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (disp_valid & ~disp_ready) | (exec_valid & ~mark_en);
    end

endmodule

// File: rtl/rob_retire_ctrl.sv
// Module rob_retire_ctrl
// Reorder-buffer retire control. The ring has 2*ENTRIES slots, and a token is
// a slot index. Dispatched instructions are retired in order once executed,
// at most MAX_RETIRE per cycle (0 = no limit). The ret_* outputs announce the
// retirement that takes effect at the next clock edge.
// Assumes the completion stage only names tokens it received from dispatch.
module rob_retire_ctrl #(
    parameter int ENTRIES    = 8,
    parameter int MAX_RETIRE = 2,
    parameter int UOP_W      = 4,
    parameter int HANDLE_W   = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       disp_valid,
    input  logic [UOP_W-1:0]                           disp_uops,
    input  logic [HANDLE_W-1:0]                        disp_handle,
    output logic                                       disp_ready,
    output logic [$clog2(2*ENTRIES)-1:0]               disp_token,
    input  logic                                       exec_valid,
    input  logic [$clog2(2*ENTRIES)-1:0]               exec_token,
    output logic                                       ret_valid,
    output logic [$clog2(((MAX_RETIRE == 0) || (MAX_RETIRE > 2*ENTRIES) ? 2*ENTRIES : MAX_RETIRE)+1)-1:0] ret_count,
    output logic [HANDLE_W-1:0]                        ret_handle,
    output logic [$clog2(ENTRIES+1)-1:0]               free_entries,
    output logic                                       err
);
    localparam int NSLOT  = 2 * ENTRIES;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int CNT_W  = $clog2(ENTRIES + 1);
    localparam int USED_W = $clog2(NSLOT + 1);
    localparam int LIMIT  = ((MAX_RETIRE == 0) || (MAX_RETIRE > NSLOT)) ? NSLOT : MAX_RETIRE;
    localparam int RET_W  = $clog2(LIMIT + 1);

    logic [SLOT_W-1:0]              head, tail, head_next;
    logic                           disp_fire, mark_en;
    logic [CNT_W-1:0]               eff_cnt, freed_entries, free_cnt;
    logic [USED_W-1:0]              freed_slots;
    logic [NSLOT-1:0]               occ, done, clr_mask;
    logic [NSLOT-1:0][CNT_W-1:0]    cnt;
    logic [NSLOT-1:0][HANDLE_W-1:0] handle;
    logic [RET_W-1:0]               ret_num;

    rcu_alloc_ctl #(
        .ENTRIES(ENTRIES), .NSLOT(NSLOT), .SLOT_W(SLOT_W),
        .CNT_W(CNT_W), .USED_W(USED_W), .UOP_W(UOP_W)
    ) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_uops(disp_uops),
        .exec_valid(exec_valid), .exec_token(exec_token),
        .occ(occ), .done(done),
        .head_next(head_next), .freed_entries(freed_entries), .freed_slots(freed_slots),
        .head(head), .tail(tail),
        .disp_ready(disp_ready), .disp_fire(disp_fire), .eff_cnt(eff_cnt),
        .mark_en(mark_en), .free_cnt(free_cnt), .err(err)
    );

    rcu_slot_array #(
        .NSLOT(NSLOT), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .HANDLE_W(HANDLE_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(disp_fire), .wr_idx(tail), .wr_cnt(eff_cnt), .wr_handle(disp_handle),
        .mark_en(mark_en), .mark_idx(exec_token),
        .clr_mask(clr_mask),
        .occ(occ), .done(done), .cnt(cnt), .handle(handle)
    );

    rcu_retire_scan #(
        .NSLOT(NSLOT), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .HANDLE_W(HANDLE_W),
        .LIMIT(LIMIT), .RET_W(RET_W), .USED_W(USED_W)
    ) u_scan (
        .head(head), .occ(occ), .done(done), .cnt(cnt), .handle(handle),
        .ret_num(ret_num), .clr_mask(clr_mask), .head_next(head_next),
        .freed_entries(freed_entries), .freed_slots(freed_slots),
        .first_handle(ret_handle)
    );

    assign disp_token   = tail;
    assign free_entries = free_cnt;
    assign ret_count    = ret_num;
    assign ret_valid    = (ret_num != '0);

endmodule

// File: rtl/rob_retire_ctrl_checker.sv
// Module rob_retire_ctrl_checker
// Port-level temporal checks for rob_retire_ctrl, attached by bind below.
module rob_retire_ctrl_checker #(
    parameter int ENTRIES    = 8,
    parameter int MAX_RETIRE = 2,
    parameter int UOP_W      = 4,
    parameter int SLOT_W     = 4,
    parameter int CNT_W      = 4,
    parameter int RET_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic [UOP_W-1:0]  disp_uops,
    input logic              disp_ready,
    input logic [SLOT_W-1:0] disp_token,
    input logic              ret_valid,
    input logic [RET_W-1:0]  ret_count,
    input logic [CNT_W-1:0]  free_entries,
    input logic              err
);
    localparam int NSLOT = 2 * ENTRIES;
    localparam int LIMIT = ((MAX_RETIRE == 0) || (MAX_RETIRE > NSLOT)) ? NSLOT : MAX_RETIRE;

    function automatic int next_tok(input int tok, input int uops);
        int e;
        e = (uops > ENTRIES) ? ENTRIES : uops;
        return (tok + ((e == 0) ? 1 : e)) % NSLOT;
    endfunction

    // R3: the free count never exceeds the buffer size
    p_free_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_entries) <= ENTRIES);

    // R8: the retire count stays within the per-cycle limit
    p_retire_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ret_count) <= LIMIT);

    // R5: a refused dispatch request raises err in the next cycle
    p_refused_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> err);

    // R2: an accepted dispatch moves the token by the clamped step
    p_token_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=>
        (int'(disp_token) == next_tok(int'($past(disp_token)), int'($past(disp_uops)))));

    // R3: without a dispatch or a retirement the free count holds
    p_free_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(disp_valid && disp_ready) && !ret_valid) |=> $stable(free_entries));

endmodule

bind rob_retire_ctrl rob_retire_ctrl_checker #(
    .ENTRIES(ENTRIES), .MAX_RETIRE(MAX_RETIRE), .UOP_W(UOP_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .RET_W(RET_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_uops(disp_uops),
    .disp_ready(disp_ready), .disp_token(disp_token), .ret_valid(ret_valid),
    .ret_count(ret_count), .free_entries(free_entries), .err(err)
);

// File: tb/rob_retire_ctrl_test.sv
`timescale 1ns/1ps
// Bench for rob_retire_ctrl: a dispatch vector table, then directed tests for
// completion errors, in-order retirement, the retire limit, clamping, and a
// second instance with no retire limit that fills the ring.
module rob_retire_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [3:0] disp_uops = '0;
    logic [7:0] disp_handle = '0;
    logic       exec_valid = 1'b0;
    logic [3:0] exec_token = '0;
    logic       disp_ready, ret_valid, err;
    logic [3:0] disp_token, free_entries;
    logic [1:0] ret_count;
    logic [7:0] ret_handle;

    logic       u_dv = 1'b0;
    logic       u_ev = 1'b0;
    logic [3:0] u_et = '0;
    logic       u_ready, u_rv, u_err;
    logic [3:0] u_tok, u_free;
    logic [4:0] u_cnt;
    logic [7:0] u_hdl;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rob_retire_ctrl #(.ENTRIES(8), .MAX_RETIRE(2), .UOP_W(4), .HANDLE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_uops(disp_uops),
        .disp_handle(disp_handle), .disp_ready(disp_ready), .disp_token(disp_token),
        .exec_valid(exec_valid), .exec_token(exec_token), .ret_valid(ret_valid),
        .ret_count(ret_count), .ret_handle(ret_handle), .free_entries(free_entries),
        .err(err)
    );

    rob_retire_ctrl #(.ENTRIES(8), .MAX_RETIRE(0), .UOP_W(4), .HANDLE_W(8)) uut_unl (
        .clk(clk), .rst_n(rst_n), .disp_valid(u_dv), .disp_uops(4'd0),
        .disp_handle(8'h55), .disp_ready(u_ready), .disp_token(u_tok),
        .exec_valid(u_ev), .exec_token(u_et), .ret_valid(u_rv),
        .ret_count(u_cnt), .ret_handle(u_hdl), .free_entries(u_free),
        .err(u_err)
    );

    // {uops, expected token, expected free entries after the edge}
    localparam logic [11:0] VEC [5] = '{
        {4'd2, 4'd0, 4'd6},
        {4'd0, 4'd2, 4'd6},
        {4'd3, 4'd3, 4'd3},
        {4'd1, 4'd6, 4'd2},
        {4'd2, 4'd7, 4'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 free after reset", int'(free_entries), 8);
        chk("R1 token after reset", int'(disp_token), 0);
        chk("R1 ret_valid after reset", int'(ret_valid), 0);
        chk("R1 err after reset", int'(err), 0);

        // R2 R3 R4: walk the dispatch table
        for (int i = 0; i < 5; i++) begin
            disp_valid  = 1'b1;
            disp_uops   = VEC[i][11:8];
            disp_handle = 8'hA0 + 8'(i);
            #0.5;
            chk("R4 ready in table", int'(disp_ready), 1);
            chk("R2 token in table", int'(disp_token), int'(VEC[i][7:4]));
            tick();
            chk("R3 free in table", int'(free_entries), int'(VEC[i][3:0]));
        end

        // R5: refused dispatch with no free entries
        disp_uops = 4'd1;
        #0.5;
        chk("R4 not ready when full", int'(disp_ready), 0);
        tick();
        disp_valid = 1'b0;
        chk("R5 err after refusal", int'(err), 1);
        chk("R5 free unchanged", int'(free_entries), 0);
        chk("R5 token unchanged", int'(disp_token), 9);

        // R6 R7: completion of a younger instruction
        exec_valid = 1'b1; exec_token = 4'd3;
        tick();
        chk("R6 legal mark no err", int'(err), 0);
        chk("R7 younger exec does not retire", int'(ret_valid), 0);
        tick();
        chk("R6 double mark err", int'(err), 1);
        exec_token = 4'd4;
        tick();
        chk("R6 non-head position err", int'(err), 1);
        exec_token = 4'd0;
        tick();
        exec_valid = 1'b0;
        chk("R7 head retires alone", int'(ret_count), 1);
        chk("R9 handle of head", int'(ret_handle), 8'hA0);
        tick();
        chk("R3 free after first retire", int'(free_entries), 2);
        chk("R7 stops at unexecuted head", int'(ret_valid), 0);

        exec_valid = 1'b1; exec_token = 4'd2;
        tick();
        chk("R8 two retire together", int'(ret_count), 2);
        chk("R9 handle of oldest", int'(ret_handle), 8'hA1);
        exec_token = 4'd6;
        tick();
        chk("R3 free after two retire", int'(free_entries), 5);
        chk("R9 next handle", int'(ret_handle), 8'hA3);
        exec_token = 4'd7;
        tick();
        exec_valid = 1'b0;
        chk("R3 free after third retire", int'(free_entries), 6);
        chk("R7 last one retires", int'(ret_count), 1);
        tick();
        chk("R3 all entries back", int'(free_entries), 8);
        chk("R7 ring drained", int'(ret_valid), 0);

        // R8: three zero-count instructions, executed youngest first
        disp_valid = 1'b1; disp_uops = 4'd0;
        for (int i = 0; i < 3; i++) begin
            disp_handle = 8'hB0 + 8'(i);
            tick();
        end
        disp_valid = 1'b0;
        chk("R3 zero count takes no entries", int'(free_entries), 8);
        chk("R2 zero count takes a slot", int'(disp_token), 12);
        exec_valid = 1'b1;
        exec_token = 4'd11; tick();
        exec_token = 4'd10; tick();
        chk("R7 young done, head not", int'(ret_valid), 0);
        exec_token = 4'd9; tick();
        exec_valid = 1'b0;
        chk("R8 limited to two", int'(ret_count), 2);
        tick();
        chk("R8 remainder next cycle", int'(ret_count), 1);
        chk("R9 handle of remainder", int'(ret_handle), 8'hB2);
        tick();
        chk("R8 ring empty", int'(ret_valid), 0);

        // R4: oversized request clamps to the buffer size
        disp_valid = 1'b1; disp_uops = 4'd12; disp_handle = 8'hC0;
        #0.5;
        chk("R4 clamp ready", int'(disp_ready), 1);
        tick();
        disp_valid = 1'b0;
        chk("R4 clamp takes all", int'(free_entries), 0);
        chk("R2 token wraps", int'(disp_token), 4);

        // R10 R8: unlimited instance fills the ring with zero-count instructions
        u_dv = 1'b1;
        for (int i = 0; i < 16; i++) tick();
        u_dv = 1'b0;
        #0.5;
        chk("R10 ring full not ready", int'(u_ready), 0);
        chk("R10 entries still free", int'(u_free), 8);
        u_ev = 1'b1;
        for (int t = 15; t >= 0; t--) begin
            u_et = 4'(t);
            tick();
        end
        u_ev = 1'b0;
        chk("R8 unlimited drains all", int'(u_cnt), 16);
        tick();
        chk("R8 unlimited ring empty", int'(u_rv), 0);
        chk("R10 ready again", int'(u_ready), 1);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 free after second reset", int'(free_entries), 8);
        chk("R1 token after second reset", int'(disp_token), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule